// File: doc/BRIEF.md
# Word Stack and Subroutine Linkage Sequencer

This block keeps the stack pointer of a processor core and carries out stack commands on its behalf. It handles pushing and popping data words, saving a return address and jumping on a near or far subroutine entry, and restoring the return address on a near or far exit. The stack lives in a segmented 20-bit byte address space. It grows toward lower addresses and is always accessed as aligned 16-bit words through a single-word memory port that uses a request/ready handshake.

The core presents a command code together with an operand word, a segment word and a jump target (offset and segment). While the block works, it holds busy high. It ends every command with a one-cycle done pulse, and in that same cycle the updated stack pointer, instruction offset, code segment and popped word are visible on its outputs. A near exit restores only the offset. A far exit restores the offset first and then the segment, which is the reverse of the order in which a far entry saved them.

Top module: `stack_call_seq`

## Requirements
- R1: The memory byte address is (stackSeg × 16 + spOut) truncated to 20 bits. The stack pointer is always even. The load command (code 7) sets it to cmdData with bit 0 forced to zero, and it makes no memory access.
- R2: Push (code 1) first lowers the stack pointer by 2 and then writes cmdData at the new top.
- R3: Pop (code 2) reads the word at the current top into popData and then raises the stack pointer by 2.
- R4: Near call (code 3) writes cmdData, the return offset, at stack pointer − 2. It then sets ipOut to targetIp and leaves csOut unchanged. The stack pointer ends 2 lower.
- R5: Far call (code 4) writes cmdSeg at stack pointer − 2 and then cmdData at stack pointer − 4, in that order. It then sets ipOut to targetIp and csOut to targetCs.
- R6: Near return (code 5) loads ipOut from the word at the top and raises the stack pointer by 2. csOut is unchanged.
- R7: Far return (code 6) loads ipOut from the top, then csOut from top + 2, and raises the stack pointer by 4 in total.
- R8: A request holds memAddr, memWe and memWdata steady until memReady. done pulses for one cycle, in the cycle after the edge that completes the final access, with all outputs already updated. A command with N accesses and W wait cycles per access gives done 1 + N·(W+1) cycles after the accept edge. busy is high from the cycle after acceptance up to, but not including, the done cycle.
- R9: A command presented while busy is high has no effect. Code 0 has no effect and produces no done.
- R10: The stack pointer wraps modulo 65536 in both directions: 0 − 2 gives 0xFFFE, and 0xFFFE + 2 gives 0.
- R11: After reset, spOut, ipOut, csOut and popData are 0, and busy, done and memReq are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| cmdValid | input | 1 | Command present; taken when busy is low |
| cmdOp | input | 3 | Command code (0 none, 1 push, 2 pop, 3 near call, 4 far call, 5 near return, 6 far return, 7 load pointer) |
| cmdData | input | 16 | Push word, return offset, or new pointer |
| cmdSeg | input | 16 | Return segment saved by a far call |
| targetIp | input | 16 | Jump offset for calls |
| targetCs | input | 16 | Jump segment for a far call |
| stackSeg | input | 16 | Stack segment base |
| busy | output | 1 | Command in progress |
| done | output | 1 | One-cycle completion pulse |
| spOut | output | 16 | Current stack pointer |
| ipOut | output | 16 | Instruction offset after the last call or return |
| csOut | output | 16 | Code segment after the last far call or return |
| popData | output | 16 | Word read by the last pop |
| memReq | output | 1 | Memory access request |
| memWe | output | 1 | Access is a write |
| memAddr | output | 20 | Byte address of the word |
| memWdata | output | 16 | Write word |
| memRdata | input | 16 | Read word |
| memReady | input | 1 | Access completes at this edge |

## Verification
The completion of one command and the acceptance of the next can happen in the same cycle. The bench drives each new command in the very cycle done is high, so commands run back to back, and it judges each one on its own addresses, data, stack pointer and latency. A second overlap is a command offered while an access is still waiting on ready. The bench stretches accesses with wait cycles, offers a push in the middle of a far call, and requires the write log and the stack pointer to show only the far call's effects.

// File: rtl/stkseq_pkg.sv
package stkseq_pkg;
  typedef enum logic [2:0] {
    OP_NOP   = 3'd0,
    OP_PUSH  = 3'd1,
    OP_POP   = 3'd2,
    OP_CALLN = 3'd3,
    OP_CALLF = 3'd4,
    OP_RETN  = 3'd5,
    OP_RETF  = 3'd6,
    OP_SETSP = 3'd7
  } stkOp_e;

  typedef struct packed {
    logic latchCmd;
    logic spDec;
    logic spInc;
    logic spLoad;
    logic wrSeg;
    logic takeIp;
    logic takeCs;
    logic takePop;
    logic jumpNear;
    logic jumpFar;
  } stkStrobe_t;
endpackage

// File: rtl/stkseq_ctrl.sv
module stkseq_ctrl
  import stkseq_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       cmdValid,
  input  logic [2:0] cmdOp,
  input  logic       memReady,
  output stkStrobe_t strobe,
  output logic       memReq,
  output logic       memWe,
  output logic       busy,
  output logic       done
);
  typedef enum logic [1:0] {ST_IDLE, ST_ACC1, ST_ACC2} seqState_e;

  seqState_e state, nextState;
  stkOp_e    opReg;
  stkOp_e    newOp;
  logic      finish;
  logic      doneReg;

  assign newOp = stkOp_e'(cmdOp);

  always_comb begin
    strobe    = '0;
    nextState = state;
    finish    = 1'b0;
    memReq    = 1'b0;
    memWe     = 1'b0;
    unique case (state)
      ST_IDLE: begin
        if (cmdValid && newOp != OP_NOP) begin
          strobe.latchCmd = 1'b1;
          unique case (newOp)
            OP_PUSH, OP_CALLN, OP_CALLF: begin
              strobe.spDec = 1'b1;
              nextState    = ST_ACC1;
            end
            OP_POP, OP_RETN, OP_RETF: nextState = ST_ACC1;
            OP_SETSP: begin
              strobe.spLoad = 1'b1;
              finish        = 1'b1;
            end
            default: ;
          endcase
        end
      end
      ST_ACC1: begin
        memReq       = 1'b1;
        memWe        = (opReg == OP_PUSH) || (opReg == OP_CALLN) || (opReg == OP_CALLF);
        strobe.wrSeg = (opReg == OP_CALLF);
        if (memReady) begin
          nextState = ST_IDLE;
          finish    = 1'b1;
          unique case (opReg)
            OP_CALLN: strobe.jumpNear = 1'b1;
            OP_CALLF: begin
              strobe.spDec = 1'b1;
              nextState    = ST_ACC2;
              finish       = 1'b0;
            end
            OP_POP: begin
              strobe.takePop = 1'b1;
              strobe.spInc   = 1'b1;
            end
            OP_RETN: begin
              strobe.takeIp = 1'b1;
              strobe.spInc  = 1'b1;
            end
            OP_RETF: begin
              strobe.takeIp = 1'b1;
              strobe.spInc  = 1'b1;
              nextState     = ST_ACC2;
              finish        = 1'b0;
            end
            default: ;
          endcase
        end
      end
      ST_ACC2: begin
        memReq = 1'b1;
        memWe  = (opReg == OP_CALLF);
        if (memReady) begin
          nextState = ST_IDLE;
          finish    = 1'b1;
          if (opReg == OP_CALLF) begin
            strobe.jumpFar = 1'b1;
          end else begin
            strobe.takeCs = 1'b1;
            strobe.spInc  = 1'b1;
          end
        end
      end
      default: nextState = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state   <= ST_IDLE;
      opReg   <= OP_NOP;
      doneReg <= 1'b0;
    end else begin
      state   <= nextState;
      doneReg <= finish;
      if (strobe.latchCmd) opReg <= newOp;
    end
  end

  assign busy = (state != ST_IDLE);
  assign done = doneReg;

  // R8: an outstanding request persists until it is granted
  assert_req_hold_R8: assert property (@(posedge clk) disable iff (!rstN)
    memReq && !memReady |=> memReq);
  // R8: done never coincides with a running command
  assert_done_idle_R8: assert property (@(posedge clk) disable iff (!rstN)
    done |-> !busy);
endmodule

// File: rtl/stkseq_dp.sv
module stkseq_dp
  import stkseq_pkg::*;
#(
  parameter int WORD_W    = 16,
  parameter int ADDR_W    = 20,
  parameter int SEG_SHIFT = 4,
  parameter logic [WORD_W-1:0] SP_RESET = '0
) (
  input  logic              clk,
  input  logic              rstN,
  input  stkStrobe_t        strobe,
  input  logic [WORD_W-1:0] cmdData,
  input  logic [WORD_W-1:0] cmdSeg,
  input  logic [WORD_W-1:0] targetIp,
  input  logic [WORD_W-1:0] targetCs,
  input  logic [WORD_W-1:0] stackSeg,
  input  logic [WORD_W-1:0] memRdata,
  output logic [WORD_W-1:0] spOut,
  output logic [WORD_W-1:0] ipOut,
  output logic [WORD_W-1:0] csOut,
  output logic [WORD_W-1:0] popData,
  output logic [ADDR_W-1:0] memAddr,
  output logic [WORD_W-1:0] memWdata
);
  localparam int SEG_W = WORD_W + SEG_SHIFT;
  localparam int BYTES = WORD_W / 8;
  localparam logic [WORD_W-1:0] STEP = WORD_W'(BYTES);

  logic [WORD_W-1:0] spReg, dataL, segL, tipL, tcsL;
  logic [WORD_W-1:0] ipReg, csReg, popReg;
  logic [SEG_W-1:0]  segBase;
  logic [ADDR_W-1:0] segPart, offPart;

  assign segBase = {stackSeg, {SEG_SHIFT{1'b0}}};

  generate
    if (SEG_W >= ADDR_W) begin : g_trunc
      assign segPart = segBase[ADDR_W-1:0];
    end else begin : g_extend
      assign segPart = {{(ADDR_W-SEG_W){1'b0}}, segBase};
    end
    if (ADDR_W > WORD_W) begin : g_offExt
      assign offPart = {{(ADDR_W-WORD_W){1'b0}}, spReg};
    end else begin : g_offTrunc
      assign offPart = spReg[ADDR_W-1:0];
    end
  endgenerate

  assign memAddr  = segPart + offPart;
  assign memWdata = strobe.wrSeg ? segL : dataL;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      spReg  <= {SP_RESET[WORD_W-1:1], 1'b0};
      dataL  <= '0;
      segL   <= '0;
      tipL   <= '0;
      tcsL   <= '0;
      ipReg  <= '0;
      csReg  <= '0;
      popReg <= '0;
    end else begin
      if (strobe.latchCmd) begin
        dataL <= cmdData;
        segL  <= cmdSeg;
        tipL  <= targetIp;
        tcsL  <= targetCs;
      end
      if (strobe.spLoad)     spReg <= {cmdData[WORD_W-1:1], 1'b0};
      else if (strobe.spDec) spReg <= spReg - STEP;
      else if (strobe.spInc) spReg <= spReg + STEP;
      if (strobe.takePop) popReg <= memRdata;
      if (strobe.takeIp)  ipReg  <= memRdata;
      if (strobe.takeCs)  csReg  <= memRdata;
      if (strobe.jumpNear || strobe.jumpFar) ipReg <= tipL;
      if (strobe.jumpFar) csReg <= tcsL;
    end
  end

  assign spOut   = spReg;
  assign ipOut   = ipReg;
  assign csOut   = csReg;
  assign popData = popReg;

  // R1: the pointer keeps word alignment through every update
  assert_sp_even_R1: assert property (@(posedge clk) disable iff (!rstN)
    !spReg[0]);
  // R3: a pop capture always comes with a pointer raise
  assert_pop_inc_R3: assert property (@(posedge clk) disable iff (!rstN)
    strobe.takePop |=> spReg == $past(spReg) + STEP);
endmodule

// File: rtl/stack_call_seq.sv
module stack_call_seq
  import stkseq_pkg::*;
#(
  parameter int WORD_W    = 16,
  parameter int ADDR_W    = 20,
  parameter int SEG_SHIFT = 4,
  parameter logic [WORD_W-1:0] SP_RESET = '0
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cmdValid,
  input  logic [2:0]        cmdOp,
  input  logic [WORD_W-1:0] cmdData,
  input  logic [WORD_W-1:0] cmdSeg,
  input  logic [WORD_W-1:0] targetIp,
  input  logic [WORD_W-1:0] targetCs,
  input  logic [WORD_W-1:0] stackSeg,
  output logic              busy,
  output logic              done,
  output logic [WORD_W-1:0] spOut,
  output logic [WORD_W-1:0] ipOut,
  output logic [WORD_W-1:0] csOut,
  output logic [WORD_W-1:0] popData,
  output logic              memReq,
  output logic              memWe,
  output logic [ADDR_W-1:0] memAddr,
  output logic [WORD_W-1:0] memWdata,
  input  logic [WORD_W-1:0] memRdata,
  input  logic              memReady
);
  stkStrobe_t strobe;

  stkseq_ctrl u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .cmdValid (cmdValid),
    .cmdOp    (cmdOp),
    .memReady (memReady),
    .strobe   (strobe),
    .memReq   (memReq),
    .memWe    (memWe),
    .busy     (busy),
    .done     (done)
  );

  stkseq_dp #(
    .WORD_W    (WORD_W),
    .ADDR_W    (ADDR_W),
    .SEG_SHIFT (SEG_SHIFT),
    .SP_RESET  (SP_RESET)
  ) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .strobe   (strobe),
    .cmdData  (cmdData),
    .cmdSeg   (cmdSeg),
    .targetIp (targetIp),
    .targetCs (targetCs),
    .stackSeg (stackSeg),
    .memRdata (memRdata),
    .spOut    (spOut),
    .ipOut    (ipOut),
    .csOut    (csOut),
    .popData  (popData),
    .memAddr  (memAddr),
    .memWdata (memWdata)
  );

  // R2: an accepted push lowers the pointer at once
  assert_push_predec_R2: assert property (@(posedge clk) disable iff (!rstN)
    cmdValid && !busy && cmdOp == OP_PUSH |=> spOut == $past(spOut) - WORD_W'(2));
  // R8: a waiting access keeps its address, direction and data
  assert_access_stable_R8: assert property (@(posedge clk) disable iff (!rstN)
    memReq && !memReady |=> $stable(memAddr) && $stable(memWe) && $stable(memWdata));
  // R8: done follows a completed access or a pointer load
  assert_done_cause_R8: assert property (@(posedge clk) disable iff (!rstN)
    done |-> $past(memReq && memReady) || $past(cmdValid && !busy && cmdOp == OP_SETSP));
  // R9: a command offered during a wait leaves the pointer alone
  assert_ignore_busy_R9: assert property (@(posedge clk) disable iff (!rstN)
    busy && cmdValid && !memReady |=> $stable(spOut));
endmodule

// File: tb/stack_call_seq_test.sv
module stack_call_seq_test;
  import stkseq_pkg::*;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        cmdValid = 1'b0;
  logic [2:0]  cmdOp = 3'd0;
  logic [15:0] cmdData = '0, cmdSeg = '0, targetIp = '0, targetCs = '0, stackSeg = '0;
  logic        busy, done, memReq, memWe, memReady;
  logic [15:0] spOut, ipOut, csOut, popData, memWdata, memRdata;
  logic [19:0] memAddr;

  always #4 clk = ~clk;

  stack_call_seq uut (
    .clk(clk), .rstN(rstN), .cmdValid(cmdValid), .cmdOp(cmdOp), .cmdData(cmdData),
    .cmdSeg(cmdSeg), .targetIp(targetIp), .targetCs(targetCs), .stackSeg(stackSeg),
    .busy(busy), .done(done), .spOut(spOut), .ipOut(ipOut), .csOut(csOut),
    .popData(popData), .memReq(memReq), .memWe(memWe), .memAddr(memAddr),
    .memWdata(memWdata), .memRdata(memRdata), .memReady(memReady)
  );

  // memory model with programmable wait states
  logic [15:0] mem [0:255];
  int waitTarget = 0;
  int waitCnt = 0;
  int wrCount = 0;
  logic [19:0] wrAddrLog [0:3];
  logic [15:0] wrDataLog [0:3];

  assign memReady = memReq && (waitCnt == waitTarget);
  assign memRdata = mem[memAddr[8:1]];

  always @(posedge clk) begin
    if (memReq) begin
      if (memReady) begin
        waitCnt <= 0;
        if (memWe) begin
          mem[memAddr[8:1]]    <= memWdata;
          wrAddrLog[wrCount%4] <= memAddr;
          wrDataLog[wrCount%4] <= memWdata;
          wrCount              <= wrCount + 1;
        end
      end else begin
        waitCnt <= waitCnt + 1;
      end
    end
  end

  int nChecks = 0;
  int nErrors = 0;
  bit finished = 0;

  logic [15:0] mMem [0:255];
  logic [15:0] mSp = '0, mIp = '0, mCs = '0, mPop = '0;

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nErrors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [19:0] addrOf(input logic [15:0] sp);
    return {stackSeg, 4'b0000} + {4'b0000, sp};
  endfunction

  // issue one command at a negedge and judge it when done appears
  task automatic doCmd(input stkOp_e op, input logic [15:0] d, input logic [15:0] s,
                       input logic [15:0] ti, input logic [15:0] tc, input bit intrude);
    int nAcc, nWr, lat, w0;
    logic [15:0] eSp, eIp, eCs, ePop;
    logic [19:0] a0, a1;
    logic [15:0] d0, d1;
    eSp = mSp; eIp = mIp; eCs = mCs; ePop = mPop;
    nAcc = 1; nWr = 0; a0 = '0; a1 = '0; d0 = '0; d1 = '0;
    case (op)
      OP_PUSH:  begin eSp = mSp - 16'd2; nWr = 1; a0 = addrOf(eSp); d0 = d; end
      OP_CALLN: begin eSp = mSp - 16'd2; nWr = 1; a0 = addrOf(eSp); d0 = d; eIp = ti; end
      OP_CALLF: begin
        eSp = mSp - 16'd4; nWr = 2; nAcc = 2;
        a0 = addrOf(mSp - 16'd2); d0 = s; a1 = addrOf(mSp - 16'd4); d1 = d;
        eIp = ti; eCs = tc;
      end
      OP_POP:   begin ePop = mMem[addrOf(mSp) >> 1 & 20'hFF]; eSp = mSp + 16'd2; end
      OP_RETN:  begin eIp = mMem[addrOf(mSp) >> 1 & 20'hFF]; eSp = mSp + 16'd2; end
      OP_RETF:  begin
        nAcc = 2;
        eIp = mMem[addrOf(mSp) >> 1 & 20'hFF];
        eCs = mMem[addrOf(mSp + 16'd2) >> 1 & 20'hFF];
        eSp = mSp + 16'd4;
      end
      OP_SETSP: begin eSp = {d[15:1], 1'b0}; nAcc = 0; end
      default: ;
    endcase
    w0 = wrCount;
    cmdValid = 1'b1; cmdOp = op; cmdData = d; cmdSeg = s; targetIp = ti; targetCs = tc;
    @(posedge clk);
    @(negedge clk);
    cmdValid = intrude; cmdOp = OP_PUSH; cmdData = 16'hDEAD;
    lat = 1;
    if (nAcc > 0) check("R8 busy after accept", {31'd0, busy}, 32'd1);
    while (!done && lat < 200) begin
      @(negedge clk);
      lat++;
      if (lat == 3) cmdValid = 1'b0;
    end
    cmdValid = 1'b0;
    check("R8 done latency", lat, 1 + nAcc * (waitTarget + 1));
    check("R8 busy low at done", {31'd0, busy}, 32'd0);
    case (op)
      OP_PUSH:  check("R2 push sp", spOut, eSp);
      OP_POP:   check("R3 pop sp", spOut, eSp);
      OP_CALLN: check("R4 near call sp", spOut, eSp);
      OP_CALLF: check("R5 far call sp", spOut, eSp);
      OP_RETN:  check("R6 near return sp", spOut, eSp);
      OP_RETF:  check("R7 far return sp", spOut, eSp);
      default:  check("R1 load sp", spOut, eSp);
    endcase
    check("R4 R5 R6 R7 ipOut", ipOut, eIp);
    check("R5 R7 csOut", csOut, eCs);
    check("R3 popData", popData, ePop);
    check(intrude ? "R9 write count" : "R2 R4 R5 write count", wrCount - w0, nWr);
    if (nWr >= 1) begin
      check("R1 R2 R5 first write addr", wrAddrLog[w0%4], a0);
      check("R2 R5 first write data", wrDataLog[w0%4], d0);
      mMem[a0 >> 1 & 20'hFF] = d0;
    end
    if (nWr == 2) begin
      check("R5 second write addr", wrAddrLog[(w0+1)%4], a1);
      check("R5 second write data", wrDataLog[(w0+1)%4], d1);
      mMem[a1 >> 1 & 20'hFF] = d1;
    end
    mSp = eSp; mIp = eIp; mCs = eCs; mPop = ePop;
  endtask

  initial begin
    repeat (2000000) @(posedge clk);
    if (!finished) begin
      nChecks++;
      nErrors++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", nErrors, nChecks);
      $finish;
    end
  end

  initial begin
    logic [15:0] segs [0:2];
    segs[0] = 16'h0000; segs[1] = 16'h1234; segs[2] = 16'hFFFF;
    for (int i = 0; i < 256; i++) begin mem[i] = '0; mMem[i] = '0; end
    repeat (3) @(posedge clk);
    @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    check("R11 sp reset", spOut, 0);
    check("R11 ip reset", ipOut, 0);
    check("R11 cs reset", csOut, 0);
    check("R11 popData reset", popData, 0);
    check("R11 ctl reset", {busy, done, memReq}, 0);

    for (int si = 0; si < 3; si++) begin
      for (int w = 0; w < 3; w++) begin
        logic [15:0] k;
        k = 16'((si * 3 + w) * 16'h0101);
        stackSeg = segs[si];
        waitTarget = w;
        doCmd(OP_SETSP, 16'h0000, 0, 0, 0, 0);
        doCmd(OP_PUSH,  16'hA000 ^ k, 0, 0, 0, 0);
        check("R10 wrap below zero", spOut, 16'hFFFE);
        doCmd(OP_PUSH,  16'hB000 ^ k, 0, 0, 0, 0);
        doCmd(OP_CALLN, 16'h1111 ^ k, 0, 16'h4000 ^ k, 0, 0);
        doCmd(OP_CALLF, 16'h2222 ^ k, 16'h3333 ^ k, 16'h5000 ^ k, 16'h6000 ^ k, 0);
        doCmd(OP_RETF,  0, 0, 0, 0, 0);
        check("R7 far return offset", ipOut, 16'h2222 ^ k);
        check("R7 far return segment", csOut, 16'h3333 ^ k);
        doCmd(OP_RETN,  0, 0, 0, 0, 0);
        check("R6 near return offset", ipOut, 16'h1111 ^ k);
        doCmd(OP_POP,   0, 0, 0, 0, 0);
        check("R3 pop last pushed", popData, 16'hB000 ^ k);
        doCmd(OP_POP,   0, 0, 0, 0, 0);
        check("R10 wrap above top", spOut, 16'h0000);
      end
    end

    stackSeg = 16'h0010;
    waitTarget = 0;
    doCmd(OP_SETSP, 16'h1235, 0, 0, 0, 0);
    check("R1 load forces even", spOut, 16'h1234);
    doCmd(OP_PUSH, 16'h7777, 0, 0, 0, 0);
    check("R1 address map", wrAddrLog[(wrCount-1)%4], 20'h00100 + 20'h01232);

    // command offered while a far call waits on memory
    waitTarget = 3;
    doCmd(OP_CALLF, 16'h0ABC, 16'h0DEF, 16'h0123, 16'h0456, 1);
    check("R9 sp unaffected by intruder", spOut, 16'h122E);

    // code 0 does nothing
    waitTarget = 0;
    cmdValid = 1'b1; cmdOp = OP_NOP; cmdData = 16'h9999;
    @(negedge clk);
    cmdValid = 1'b0;
    repeat (3) @(negedge clk);
    check("R9 nop no done", {31'd0, done}, 0);
    check("R9 nop no request", {31'd0, memReq}, 0);
    check("R9 nop sp", spOut, mSp);

    finished = 1;
    $display("Result: errors=%0d of %0d checks", nErrors, nChecks);
    $finish;
  end
endmodule